// File: doc/BRIEF.md
# SMBus Master Error Status Tracker

This block gathers the error and progress conditions of an SMBus master engine and of a configuration loader that initializes registers from a serial EEPROM. It presents them, together with the strapped bus addresses, as a single 32-bit status word. The master engine and the loader report single-cycle event pulses. The block turns those pulses into flags and tracks arbitration losses. After each loss it tells the master to try again. When the run of consecutive losses reaches a parameterized limit, it tells the master to abort.

Software reads the word through a plain read port and writes it through a write-enable/data port. The error flags clear when a 1 is written to them. The hot-plug expander address field can be rewritten until a lock input is seen. The loader-done flag and the strapped addresses cannot be changed by software.

Top module: `smb_err_status`

## Requirements
- R1: After reset the status word reads as the two strap addresses in their fields with every other bit 0, and `arb_retry` and `arb_abort` are 0.
- R2: An arbitration-loss pulse that is not the limit-th consecutive loss makes `arb_retry` high for exactly the next cycle, with `arb_abort` low.
- R3: The MAX_LOSSES-th consecutive loss (16 by default) makes `arb_abort` high for exactly the next cycle, with `arb_retry` low. In the same cycle, bit 26 (lost-arbitration flag) reads 1.
- R4: The consecutive-loss count returns to zero on an arbitration-won pulse, on a transfer-done pulse and on an abort. A won or done pulse in the same cycle as a loss wins, and no retry follows.
- R5: An unexpected-NACK pulse sets bit 25 in the next cycle.
- R6: A misplaced START/STOP pulse sets bit 27 in the next cycle.
- R7: Bits 25 to 29 are sticky. Writing 1 to one of them clears it, and writing 0 leaves it as it is.
- R8: When a set event and a write-1 clear hit the same flag in the same cycle, the flag reads 1 afterwards.
- R9: Bit 24 (loader finished) is set by a loader-done pulse, or by a checksum-bad or missing-end-command pulse. It stays set until reset, and writes have no effect on it.
- R10: Bit 28 is set by a checksum-bad or a missing-end-command pulse. Bit 29 is set by an unmapped-register-write pulse.
- R11: Bits 7:1 carry `strap_slv_addr`, bits 15:9 carry `strap_mst_addr`, and bits 0, 8, 16, 30 and 31 always read 0.
- R12: Bits 23:17 (expander address) reset to 0 and take `wr_data[23:17]` on a write. Once `ioexp_lock` has been high in any cycle, writes to the field are ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_slv_addr | input | 7 | Hardware-initialized slave address |
| strap_mst_addr | input | 7 | Hardware-initialized master address |
| ioexp_lock | input | 1 | Freezes the expander address field until reset |
| evt_arb_lost | input | 1 | Master lost arbitration (pulse) |
| evt_arb_won | input | 1 | Master won arbitration (pulse) |
| evt_nack | input | 1 | Unexpected NACK in a master transfer (pulse) |
| evt_misplaced | input | 1 | Misplaced START or STOP seen (pulse) |
| evt_xfer_done | input | 1 | Master transfer completed (pulse) |
| ld_done | input | 1 | Loader finished initialization (pulse) |
| ld_csum_bad | input | 1 | Loader computed a bad checksum (pulse) |
| ld_no_end_cmd | input | 1 | Loader found no configuration-end command (pulse) |
| ld_unmapped | input | 1 | Loader tried to write an undefined register (pulse) |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 32 | Status word write data |
| rd_data | output | 32 | Status word |
| arb_retry | output | 1 | Re-arbitrate request (pulse) |
| arb_abort | output | 1 | Abort transfer request (pulse) |

## Verification
The bench builds the block with the default limit of 16 consecutive losses. This is small enough to drive a full run of 15 losses, break it with a won pulse and with a done pulse, and then reach the abort on the sixteenth loss in a few dozen cycles. It also checks that the count restarts after an abort. The strap inputs use two distinct, asymmetric addresses, so a misplaced field or a stray reserved bit shows up in the compared word.

// File: rtl/smb_err_pkg.sv
package smb_err_pkg;
  localparam int ADDR_W    = 7;
  localparam int WORD_W    = 32;
  localparam int SLV_LSB   = 1;
  localparam int MST_LSB   = 9;
  localparam int EXP_LSB   = 17;
  localparam int DONE_BIT  = 24;
  localparam int FLAG_LSB  = 25;
  localparam int NUM_FLAGS = 5;

  // flag order inside the sticky vector (bit FLAG_LSB + index)
  typedef enum int {
    FL_NACK  = 0,
    FL_ARB   = 1,
    FL_MISP  = 2,
    FL_INIT  = 3,
    FL_UNMAP = 4
  } flag_idx_e;
endpackage

// File: rtl/arb_loss_tracker.sv
module arb_loss_tracker #(
  parameter int MAX_LOSSES = 16,
  localparam int CNT_W = (MAX_LOSSES > 2) ? $clog2(MAX_LOSSES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lost,
  input  logic won,
  input  logic done,
  output logic retry,
  output logic abort,
  output logic abort_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             retry_d, abort_d;
  logic             at_limit;

  assign at_limit = (cnt_q == CNT_W'(MAX_LOSSES - 1));

  always_comb begin
    cnt_d   = cnt_q;
    retry_d = 1'b0;
    abort_d = 1'b0;
    if (won || done) begin
      cnt_d = '0;
    end else if (lost) begin
      if (at_limit) begin
        cnt_d   = '0;
        abort_d = 1'b1;
      end else begin
        cnt_d   = cnt_q + 1'b1;
        retry_d = 1'b1;
      end
    end
  end

  assign abort_evt = abort_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      retry <= 1'b0;
      abort <= 1'b0;
    end else begin
      if (lost || won || done) cnt_q <= cnt_d;
      retry <= retry_d;
      abort <= abort_d;
    end
  end
endmodule

// File: rtl/w1c_flag.sv
module w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;

  // a hardware set overrides a software clear
  always_comb begin
    q_d = q;
    if (set)      q_d = 1'b1;
    else if (clr) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= 1'b0;
    else if (set | clr) q <= q_d;
  end
endmodule

// File: rtl/exp_addr_reg.sv
module exp_addr_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         lock_in,
  output logic [W-1:0] addr
);
  logic         lock_q;
  logic         upd;
  logic [W-1:0] addr_d;

  assign upd    = wr_en && !lock_q && !lock_in;
  assign addr_d = wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      addr   <= '0;
    end else begin
      if (lock_in) lock_q <= 1'b1;
      if (upd)     addr   <= addr_d;
    end
  end
endmodule

// File: rtl/smb_err_status.sv
module smb_err_status
  import smb_err_pkg::*;
#(
  parameter int MAX_LOSSES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_slv_addr,
  input  logic [ADDR_W-1:0] strap_mst_addr,
  input  logic              ioexp_lock,
  input  logic              evt_arb_lost,
  input  logic              evt_arb_won,
  input  logic              evt_nack,
  input  logic              evt_misplaced,
  input  logic              evt_xfer_done,
  input  logic              ld_done,
  input  logic              ld_csum_bad,
  input  logic              ld_no_end_cmd,
  input  logic              ld_unmapped,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              arb_retry,
  output logic              arb_abort
);
  logic                 abort_evt;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic [ADDR_W-1:0]    exp_addr;
  logic                 done_q, done_d, done_set;
  logic                 wr_unused;

  assign wr_unused = ^{wr_data[EXP_LSB-1:0], wr_data[DONE_BIT], wr_data[WORD_W-1:FLAG_LSB+NUM_FLAGS]};

  arb_loss_tracker #(.MAX_LOSSES(MAX_LOSSES)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .lost(evt_arb_lost), .won(evt_arb_won), .done(evt_xfer_done),
    .retry(arb_retry), .abort(arb_abort), .abort_evt(abort_evt)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FL_NACK]  = evt_nack;
    flag_set[FL_ARB]   = abort_evt;
    flag_set[FL_MISP]  = evt_misplaced;
    flag_set[FL_INIT]  = ld_csum_bad | ld_no_end_cmd;
    flag_set[FL_UNMAP] = ld_unmapped;
  end

  assign flag_clr = wr_en ? wr_data[FLAG_LSB +: NUM_FLAGS] : '0;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    w1c_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set(flag_set[i]), .clr(flag_clr[i]), .q(flag_q[i])
    );
  end

  exp_addr_reg #(.W(ADDR_W)) u_exp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_val(wr_data[EXP_LSB +: ADDR_W]), .lock_in(ioexp_lock), .addr(exp_addr)
  );

  assign done_set = ld_done | ld_csum_bad | ld_no_end_cmd;
  assign done_d   = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (done_set) done_q <= done_d;
  end

  always_comb begin
    rd_data                          = '0;
    rd_data[SLV_LSB +: ADDR_W]       = strap_slv_addr;
    rd_data[MST_LSB +: ADDR_W]       = strap_mst_addr;
    rd_data[EXP_LSB +: ADDR_W]       = exp_addr;
    rd_data[DONE_BIT]                = done_q;
    rd_data[FLAG_LSB +: NUM_FLAGS]   = flag_q;
  end
endmodule

// File: rtl/smb_err_status_chk.sv
module smb_err_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ioexp_lock,
  input logic        evt_arb_lost,
  input logic        evt_arb_won,
  input logic        evt_xfer_done,
  input logic        evt_nack,
  input logic        evt_misplaced,
  input logic [31:0] rd_data,
  input logic        arb_retry,
  input logic        arb_abort
);
  p_retry_abort_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(arb_retry && arb_abort));

  p_loss_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_arb_lost && !evt_arb_won && !evt_xfer_done) |=> (arb_retry || arb_abort));

  p_clear_no_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_arb_won || evt_xfer_done) |=> (!arb_retry && !arb_abort));

  p_abort_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_abort |-> rd_data[26]);

  p_nack_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_nack |=> rd_data[25]);

  p_misplaced_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_misplaced |=> rd_data[27]);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[24] |=> rd_data[24]);

  p_lock_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ioexp_lock |=> $stable(rd_data[23:17]));

  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] == 1'b0) && (rd_data[8] == 1'b0) && (rd_data[16] == 1'b0) && (rd_data[31:30] == 2'b00));
endmodule

bind smb_err_status smb_err_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ioexp_lock(ioexp_lock),
  .evt_arb_lost(evt_arb_lost), .evt_arb_won(evt_arb_won), .evt_xfer_done(evt_xfer_done),
  .evt_nack(evt_nack), .evt_misplaced(evt_misplaced),
  .rd_data(rd_data), .arb_retry(arb_retry), .arb_abort(arb_abort)
);

// File: tb/smb_err_status_tb.sv
module smb_err_status_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  strap_slv_addr = 7'h2A;
  logic [6:0]  strap_mst_addr = 7'h51;
  logic        ioexp_lock, evt_arb_lost, evt_arb_won, evt_nack, evt_misplaced, evt_xfer_done;
  logic        ld_done, ld_csum_bad, ld_no_end_cmd, ld_unmapped, wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        arb_retry, arb_abort;

  always #2 clk = ~clk;

  smb_err_status u_dut (
    .clk(clk), .rst_n(rst_n), .strap_slv_addr(strap_slv_addr), .strap_mst_addr(strap_mst_addr),
    .ioexp_lock(ioexp_lock), .evt_arb_lost(evt_arb_lost), .evt_arb_won(evt_arb_won),
    .evt_nack(evt_nack), .evt_misplaced(evt_misplaced), .evt_xfer_done(evt_xfer_done),
    .ld_done(ld_done), .ld_csum_bad(ld_csum_bad), .ld_no_end_cmd(ld_no_end_cmd),
    .ld_unmapped(ld_unmapped), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .arb_retry(arb_retry), .arb_abort(arb_abort)
  );

  int          errs = 0;
  int          checks = 0;
  bit          finished = 1'b0;
  string       tag_q[$];
  logic [33:0] exp_q[$];

  localparam logic [31:0] BASE = (32'h2A << 1) | (32'h51 << 9);
  function automatic logic [31:0] expf(logic [6:0] a);
    return {8'b0, a, 17'b0};
  endfunction

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    while (tag_q.size() > 0) begin
      string       t;
      logic [33:0] e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      checks++;
      if ({arb_retry, arb_abort, rd_data} !== e) begin
        errs++;
        $display("FAIL %s: got retry/abort/word=%b/%b/%h expected %b/%b/%h",
                 t, arb_retry, arb_abort, rd_data, e[33], e[32], e[31:0]);
      end
    end
  end

  task automatic clr_in();
    ioexp_lock = 0; evt_arb_lost = 0; evt_arb_won = 0; evt_nack = 0; evt_misplaced = 0;
    evt_xfer_done = 0; ld_done = 0; ld_csum_bad = 0; ld_no_end_cmd = 0; ld_unmapped = 0;
    wr_en = 0; wr_data = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    clr_in();
  endtask

  task automatic push(string t, logic [31:0] w, bit rt, bit ab);
    tag_q.push_back(t);
    exp_q.push_back({rt, ab, w});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; clr_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic lose(string t, logic [31:0] w, bit rt, bit ab);
    @(negedge clk); evt_arb_lost = 1; tick(); push(t, w, rt, ab);
  endtask

  task automatic write(logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    clr_in();
    do_reset();
    tick();
    push("R1 R11 reset word", BASE, 0, 0);

    // R12 expander address write
    write(expf(7'h33));
    w = BASE | expf(7'h33);
    push("R12 expander write", w, 0, 0);

    // R2 single loss -> retry, then idle
    lose("R2 first loss retry", w, 1, 0);
    @(negedge clk); tick(); push("R2 retry is a pulse", w, 0, 0);

    // R4 win clears the count (1 + 14 = 15 losses, then won)
    for (int i = 0; i < 14; i++) lose("R2 loss below limit", w, 1, 0);
    @(negedge clk); evt_arb_won = 1; tick(); push("R4 won clears", w, 0, 0);
    for (int i = 0; i < 15; i++) lose("R4 count restarted after win", w, 1, 0);
    // R4 loss together with done: done wins, no retry
    @(negedge clk); evt_arb_lost = 1; evt_xfer_done = 1; tick();
    push("R4 done beats loss", w, 0, 0);

    // R3 sixteen consecutive losses -> abort and flag 26
    for (int i = 0; i < 15; i++) lose("R3 loss before limit", w, 1, 0);
    w = w | (32'h1 << 26);
    lose("R3 sixteenth loss aborts", w, 0, 1);
    @(negedge clk); tick(); push("R3 abort is a pulse", w, 0, 0);
    lose("R4 count cleared by abort", w, 1, 0);

    // R5 / R6
    @(negedge clk); evt_nack = 1; tick();
    w = w | (32'h1 << 25); push("R5 nack flag", w, 0, 0);
    @(negedge clk); evt_misplaced = 1; tick();
    w = w | (32'h1 << 27); push("R6 misplaced flag", w, 0, 0);

    // R7 write 0 keeps, write 1 clears only the addressed flag
    write(expf(7'h33));
    push("R7 write zero keeps flags", w, 0, 0);
    write(expf(7'h33) | (32'h1 << 25));
    w = w & ~(32'h1 << 25); push("R7 write one clears bit 25", w, 0, 0);

    // R8 set beats clear
    @(negedge clk); evt_nack = 1; wr_en = 1; wr_data = expf(7'h33) | (32'h1 << 25); tick();
    w = w | (32'h1 << 25); push("R8 set wins over clear", w, 0, 0);

    // R9 / R10 checksum error ends init
    @(negedge clk); ld_csum_bad = 1; tick();
    w = w | (32'h1 << 24) | (32'h1 << 28); push("R9 R10 checksum bad", w, 0, 0);
    write(expf(7'h33) | (32'h1 << 24) | (32'h1 << 28));
    w = w & ~(32'h1 << 28); push("R9 done ignores write, R7 clear 28", w, 0, 0);
    @(negedge clk); ld_unmapped = 1; tick();
    w = w | (32'h1 << 29); push("R10 unmapped flag", w, 0, 0);

    // R12 lock freezes the field
    @(negedge clk); ioexp_lock = 1; wr_en = 1; wr_data = expf(7'h11); tick();
    push("R12 write with lock ignored", w, 0, 0);
    write(expf(7'h11));
    push("R12 lock held after release", w, 0, 0);

    // fresh reset: lock and field cleared, loader done path
    do_reset();
    tick();
    push("R1 R12 reset clears field", BASE, 0, 0);
    write(expf(7'h11));
    w = BASE | expf(7'h11); push("R12 writable after reset", w, 0, 0);
    @(negedge clk); ld_done = 1; tick();
    w = w | (32'h1 << 24); push("R9 loader done", w, 0, 0);
    @(negedge clk); ld_no_end_cmd = 1; tick();
    w = w | (32'h1 << 28); push("R10 missing end command", w, 0, 0);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule